// File: doc/BRIEF.md
# Retimed I2S Stereo Transmitter

This block turns a stream of 16-bit stereo PCM pairs into a three-wire I2S stream (bit clock, word select, serial data) for an audio DAC running at 44.1 kHz. Its only clock is the audio master clock, nominally 11.2896 MHz. A counter divides that clock by eight to make a 1.4112 MHz bit clock. A frame counter steps through 32 bit-clock slots per stereo frame, and a shift register carries the samples out.

The bit clock, word select and data are not taken straight from the divider and counter logic. All three pass through one last bank of flip-flops clocked by the master clock. Every edge seen by the DAC therefore sits on a master-clock edge, and the three lines keep a fixed alignment to each other. An upstream source offers one stereo pair at a time with a valid/ready handshake. The block takes at most one pair per frame. When no pair is waiting at a frame boundary, it sends a silent frame of zeros.

Top module: `i2s_retimed_tx`

## Requirements
- R1: The bit clock `i2s_bclk` has a period of BCLK_DIV master clocks. It stays high for BCLK_DIV/2 cycles and low for BCLK_DIV/2 cycles.
- R2: A frame spans 2*SAMPLE_W bit-clock periods, numbered slot 0 to 2*SAMPLE_W-1. Word select `i2s_ws` is 1 in slots SAMPLE_W-1 to 2*SAMPLE_W-2 and 0 in all other slots. Low means left and high means right, and word select therefore switches one slot before each word's MSB.
- R3: Slots 0 to SAMPLE_W-1 carry the left sample, MSB first. Each bit is valid on the rising edge of the bit clock.
- R4: `i2s_ws` and `i2s_sd` change only in the master-clock cycle in which `i2s_bclk` falls. All three lines come from one final register stage.
- R5: A pair moves when `pair_valid` and `pair_ready` are both high at a master-clock edge. After each transfer `pair_ready` is low until the next frame begins, so at most one pair is accepted per frame.
- R6: Slots SAMPLE_W to 2*SAMPLE_W-1 carry the right sample, MSB first. A pair accepted at master-clock edge A is sent in the frame whose slot-0 falling edge appears at the outputs after edge A+1. Pairs go out in order of acceptance and none is lost.
- R7: A frame that starts with no accepted pair waiting sends zero in both words. While nothing is waiting, `pair_ready` stays high.
- R8: While `rst` is high, `i2s_bclk`, `i2s_ws`, `i2s_sd` and `pair_ready` are low. After release, the first rising edge of `i2s_bclk` appears BCLK_DIV/2+1 master clocks later, with word select and data both 0. The following falling edge starts slot 0 of the first frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Audio master clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_valid | input | 1 | Stereo pair offered |
| pair_ready | output | 1 | Pair holding register is free |
| pair_left | input | SAMPLE_W | Left sample, two's complement |
| pair_right | input | SAMPLE_W | Right sample, two's complement |
| i2s_bclk | output | 1 | Retimed bit clock |
| i2s_ws | output | 1 | Retimed word select, 0 = left |
| i2s_sd | output | 1 | Retimed serial data |

## Verification
The hardest case to reach is a pair that arrives a few master clocks before or after the internal frame boundary. A pair in that window either makes the coming frame or is held back for the next one. The stimulus mixes random idle gaps of up to 300 master clocks between offers, so offers land at every phase of the 256-cycle frame. A long directed idle stretch forces silent frames. A reset asserted in the middle of a frame, with a pair still held, checks that the block restarts on a clean frame boundary.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int unsigned DEF_SAMPLE_W = 16;
    localparam int unsigned DEF_BCLK_DIV = 8;

    // word select polarity: low = left word, high = right word
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } i2s_chan_e;

    // the three serial lines as they leave the block
    typedef struct packed {
        logic bclk;
        logic ws;
        logic sd;
    } i2s_lines_t;

    function automatic int unsigned frame_slots(input int unsigned w);
        return 2 * w;
    endfunction

    // word select for a slot: it switches one slot ahead of each MSB
    function automatic i2s_chan_e chan_of_slot(input int unsigned slot,
                                               input int unsigned w);
        if (slot >= w - 1 && slot < 2 * w - 1)
            return CH_RIGHT;
        return CH_LEFT;
    endfunction

endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
    parameter int unsigned BCLK_DIV = 8
) (
    input  logic mclk,
    input  logic rst,
    output logic bclk_int,
    output logic fall_tick
);
    localparam int unsigned HALF = BCLK_DIV / 2;
    localparam int unsigned CW   = (BCLK_DIV > 2) ? $clog2(BCLK_DIV) : 1;
    localparam logic [CW-1:0] LAST_PH = CW'(BCLK_DIV - 1);
    localparam logic [CW-1:0] RISE_PH = CW'(HALF - 1);

    logic [CW-1:0] phase_q;

    // the bit clock falls on the edge that wraps the phase counter
    assign fall_tick = (phase_q == LAST_PH);

    always_ff @(posedge mclk) begin
        if (rst) begin
            phase_q  <= '0;
            bclk_int <= 1'b0;
        end else begin
            phase_q <= fall_tick ? '0 : phase_q + 1'b1;
            if (phase_q == RISE_PH)
                bclk_int <= 1'b1;
            else if (fall_tick)
                bclk_int <= 1'b0;
        end
    end

endmodule

// File: rtl/i2s_tx_pair_buf.sv
module i2s_tx_pair_buf #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                    mclk,
    input  logic                    rst,
    input  logic                    pair_valid,
    input  logic [SAMPLE_W-1:0]     pair_left,
    input  logic [SAMPLE_W-1:0]     pair_right,
    input  logic                    take,
    output logic                    pair_ready,
    output logic [2*SAMPLE_W-1:0]   frame_word
);
    logic                  full_q;
    logic [2*SAMPLE_W-1:0] hold_q;
    logic                  accept;

    assign pair_ready = !full_q && !rst;
    assign accept     = pair_valid && pair_ready;

    // an accept can only coincide with take when the holder is empty,
    // in which case the frame starting now goes out silent
    always_ff @(posedge mclk) begin
        if (rst) begin
            full_q <= 1'b0;
            hold_q <= '0;
        end else if (accept) begin
            full_q <= 1'b1;
            hold_q <= {pair_left, pair_right};
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign frame_word = full_q ? hold_q : '0;

endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer
    import i2s_tx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                    mclk,
    input  logic                    rst,
    input  logic                    fall_tick,
    input  logic [2*SAMPLE_W-1:0]   frame_word,
    output logic                    take,
    output i2s_chan_e               ws_int,
    output logic                    sd_int
);
    localparam int unsigned SLOTS = frame_slots(SAMPLE_W);
    localparam int unsigned SW    = $clog2(SLOTS);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    logic [SW-1:0]    slot_q;
    logic [SW-1:0]    slot_n;
    logic [SLOTS-1:0] shreg_q;

    always_comb begin
        slot_n = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end

    // leaving the last slot opens a new frame and loads the next pair
    assign take = fall_tick && (slot_q == LAST_SLOT);

    // reset parks the counter in the last slot so the first falling
    // edge after release begins slot 0 of a full frame
    always_ff @(posedge mclk) begin
        if (rst) begin
            slot_q  <= LAST_SLOT;
            ws_int  <= CH_LEFT;
            shreg_q <= '0;
        end else if (fall_tick) begin
            slot_q  <= slot_n;
            ws_int  <= chan_of_slot(32'(slot_n), SAMPLE_W);
            shreg_q <= take ? frame_word : {shreg_q[SLOTS-2:0], 1'b0};
        end
    end

    assign sd_int = shreg_q[SLOTS-1];

endmodule

// File: rtl/i2s_tx_retime.sv
module i2s_tx_retime #(
    parameter int unsigned LINES = 3
) (
    input  logic             mclk,
    input  logic             rst,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic line_q;
        always_ff @(posedge mclk) begin
            if (rst)
                line_q <= 1'b0;
            else
                line_q <= d[i];
        end
        assign q[i] = line_q;
    end

endmodule

// File: rtl/i2s_retimed_tx.sv
module i2s_retimed_tx
    import i2s_tx_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned BCLK_DIV = DEF_BCLK_DIV
) (
    input  logic                mclk,
    input  logic                rst,
    input  logic                pair_valid,
    output logic                pair_ready,
    input  logic [SAMPLE_W-1:0] pair_left,
    input  logic [SAMPLE_W-1:0] pair_right,
    output logic                i2s_bclk,
    output logic                i2s_ws,
    output logic                i2s_sd
);
    localparam int unsigned NLINES = $bits(i2s_lines_t);

    logic                  bclk_int;
    logic                  fall_tick;
    logic                  take;
    logic [2*SAMPLE_W-1:0] frame_word;
    i2s_chan_e             ws_int;
    logic                  sd_int;
    i2s_lines_t            pre_lines;
    i2s_lines_t            out_lines;

    i2s_tx_clkgen #(.BCLK_DIV(BCLK_DIV)) u_clkgen (
        .mclk      (mclk),
        .rst       (rst),
        .bclk_int  (bclk_int),
        .fall_tick (fall_tick)
    );

    i2s_tx_pair_buf #(.SAMPLE_W(SAMPLE_W)) u_pair_buf (
        .mclk       (mclk),
        .rst        (rst),
        .pair_valid (pair_valid),
        .pair_left  (pair_left),
        .pair_right (pair_right),
        .take       (take),
        .pair_ready (pair_ready),
        .frame_word (frame_word)
    );

    i2s_tx_framer #(.SAMPLE_W(SAMPLE_W)) u_framer (
        .mclk       (mclk),
        .rst        (rst),
        .fall_tick  (fall_tick),
        .frame_word (frame_word),
        .take       (take),
        .ws_int     (ws_int),
        .sd_int     (sd_int)
    );

    always_comb begin
        pre_lines.bclk = bclk_int;
        pre_lines.ws   = logic'(ws_int);
        pre_lines.sd   = sd_int;
    end

    // one shared master-clock stage: every output edge lands on mclk
    i2s_tx_retime #(.LINES(NLINES)) u_retime (
        .mclk (mclk),
        .rst  (rst),
        .d    (pre_lines),
        .q    (out_lines)
    );

    assign i2s_bclk = out_lines.bclk;
    assign i2s_ws   = out_lines.ws;
    assign i2s_sd   = out_lines.sd;

endmodule

// File: rtl/i2s_retimed_tx_chk.sv
module i2s_retimed_tx_chk #(
    parameter int unsigned BCLK_DIV = 8
) (
    input logic mclk,
    input logic rst,
    input logic pair_valid,
    input logic pair_ready,
    input logic i2s_bclk,
    input logic i2s_ws,
    input logic i2s_sd
);
    localparam logic [15:0] HALF = 16'(BCLK_DIV / 2);

    logic        prev_bclk;
    logic        seen_fall;
    logic [15:0] run_q;

    // length of the current bit-clock level, counted in master clocks
    always_ff @(posedge mclk) begin
        if (rst) begin
            prev_bclk <= 1'b0;
            seen_fall <= 1'b0;
            run_q     <= '0;
        end else begin
            prev_bclk <= i2s_bclk;
            if (i2s_bclk == prev_bclk) begin
                run_q <= run_q + 1'b1;
            end else begin
                run_q <= 16'd1;
                if (!i2s_bclk)
                    seen_fall <= 1'b1;
            end
        end
    end

    // R1: each bit-clock level lasts half the divide ratio
    a_r1_half_period: assert property (@(posedge mclk) disable iff (rst)
        (seen_fall && (i2s_bclk != prev_bclk)) |-> (run_q == HALF));

    // R4: word select moves only with a bit-clock falling edge
    a_r4_ws_on_fall: assert property (@(posedge mclk) disable iff (rst)
        !$stable(i2s_ws) |-> $fell(i2s_bclk));

    // R4: data moves only with a bit-clock falling edge
    a_r4_sd_on_fall: assert property (@(posedge mclk) disable iff (rst)
        !$stable(i2s_sd) |-> $fell(i2s_bclk));

    // R5: a transfer closes the holder until the next frame
    a_r5_one_per_frame: assert property (@(posedge mclk) disable iff (rst)
        (pair_valid && pair_ready) |=> !pair_ready);

    // R8: reset drives every serial line low
    a_r8_reset_quiet: assert property (@(posedge mclk)
        rst |=> (!i2s_bclk && !i2s_ws && !i2s_sd));

endmodule

bind i2s_retimed_tx i2s_retimed_tx_chk #(.BCLK_DIV(BCLK_DIV)) u_chk (
    .mclk       (mclk),
    .rst        (rst),
    .pair_valid (pair_valid),
    .pair_ready (pair_ready),
    .i2s_bclk   (i2s_bclk),
    .i2s_ws     (i2s_ws),
    .i2s_sd     (i2s_sd)
);

// File: tb/i2s_retimed_tx_bench.sv
module i2s_retimed_tx_bench;
    localparam int W     = 16;
    localparam int DIV   = 8;
    localparam int HALF  = DIV / 2;
    localparam int SLOTS = 2 * W;

    logic         mclk = 1'b0;
    logic         rst = 1'b1;
    logic         pair_valid = 1'b0;
    logic [W-1:0] pair_left = '0;
    logic [W-1:0] pair_right = '0;
    logic         pair_ready;
    logic         i2s_bclk;
    logic         i2s_ws;
    logic         i2s_sd;

    always #10 mclk = ~mclk;

    i2s_retimed_tx #(.SAMPLE_W(W), .BCLK_DIV(DIV)) u_i2s_retimed_tx (
        .mclk       (mclk),
        .rst        (rst),
        .pair_valid (pair_valid),
        .pair_ready (pair_ready),
        .pair_left  (pair_left),
        .pair_right (pair_right),
        .i2s_bclk   (i2s_bclk),
        .i2s_ws     (i2s_ws),
        .i2s_sd     (i2s_sd)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int frames_done = 0;

    logic [SLOTS-1:0] q_data[$];
    int               q_edge[$];

    always @(posedge mclk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic ws_expected(input int s);
        return (s >= W - 1) && (s < SLOTS - 1);
    endfunction

    // ---------------- output monitor ----------------
    int               since_rel = 0;
    int               slot = SLOTS - 2;
    int               run = 0;
    bit               seen_edge = 0;
    bit               collecting = 0;
    bit               exp_zero = 0;
    logic             prev_b = 0, prev_ws = 0, prev_sd = 0;
    logic [SLOTS-1:0] got = '0;
    logic [SLOTS-1:0] exp_frame = '0;

    always @(negedge mclk) begin
        if (rst) begin
            check({i2s_bclk, i2s_ws, i2s_sd} == 3'b000, "R8", "lines in reset",
                  {29'd0, i2s_bclk, i2s_ws, i2s_sd}, 0);
            check(pair_ready == 1'b0, "R8", "ready in reset", pair_ready, 0);
            since_rel  = 0;
            slot       = SLOTS - 2;
            run        = 0;
            seen_edge  = 0;
            collecting = 0;
            prev_b = 0; prev_ws = 0; prev_sd = 0;
        end else begin
            since_rel++;
            if (since_rel <= HALF + 1)
                check(i2s_bclk == (since_rel == HALF + 1), "R8", "first bclk rise timing",
                      i2s_bclk, (since_rel == HALF + 1));
            if (since_rel == HALF + 1)
                check({i2s_ws, i2s_sd} == 2'b00, "R8", "ws/sd at first rise",
                      {i2s_ws, i2s_sd}, 0);

            // R1 level lengths
            if (i2s_bclk == prev_b) begin
                run++;
            end else begin
                if (seen_edge)
                    check(run == HALF, "R1", "bclk level length", run, HALF);
                seen_edge = 1;
                run = 1;
            end

            // R4 alignment with the falling edge
            if (i2s_ws != prev_ws)
                check(prev_b && !i2s_bclk, "R4", "ws moved off a falling edge",
                      i2s_bclk, 0);
            if (i2s_sd != prev_sd)
                check(prev_b && !i2s_bclk, "R4", "sd moved off a falling edge",
                      i2s_bclk, 0);

            // frame start at the outputs
            if (prev_b && !i2s_bclk && slot == SLOTS - 1) begin
                if (q_data.size() > 0 && q_edge[0] < cyc - 1) begin
                    exp_frame = q_data.pop_front();
                    void'(q_edge.pop_front());
                    exp_zero = 0;
                end else begin
                    exp_frame = '0;
                    exp_zero = 1;
                end
                collecting = 1;
                got = '0;
            end

            if (!prev_b && i2s_bclk) begin
                slot = (slot == SLOTS - 1) ? 0 : slot + 1;
                check(i2s_ws == ws_expected(slot), "R2", "ws in slot",
                      i2s_ws, ws_expected(slot));
                if (collecting) begin
                    got = {got[SLOTS-2:0], i2s_sd};
                    if (slot == SLOTS - 1) begin
                        check(got[SLOTS-1:W] == exp_frame[SLOTS-1:W],
                              exp_zero ? "R7" : "R3", "left word",
                              32'(got[SLOTS-1:W]), 32'(exp_frame[SLOTS-1:W]));
                        check(got[W-1:0] == exp_frame[W-1:0],
                              exp_zero ? "R7" : "R6", "right word",
                              32'(got[W-1:0]), 32'(exp_frame[W-1:0]));
                        frames_done++;
                    end
                end
            end
            prev_b = i2s_bclk; prev_ws = i2s_ws; prev_sd = i2s_sd;
        end
    end

    // ---------------- stimulus ----------------
    bit last_acc = 0;

    task automatic tick(input bit v, input logic [W-1:0] l, input logic [W-1:0] r,
                        output bit acc);
        @(negedge mclk);
        #1;
        pair_valid = v; pair_left = l; pair_right = r;
        #2;
        if (last_acc)
            check(pair_ready == 1'b0, "R5", "ready after transfer", pair_ready, 0);
        acc = v && pair_ready;
        if (acc) begin
            q_data.push_back({l, r});
            q_edge.push_back(cyc + 1);
        end
        last_acc = acc;
    endtask

    task automatic send(input logic [W-1:0] l, input logic [W-1:0] r);
        bit a;
        a = 0;
        while (!a) tick(1'b1, l, r, a);
    endtask

    task automatic idle(input int n);
        bit a;
        for (int i = 0; i < n; i++) tick(1'b0, '0, '0, a);
    endtask

    task automatic do_reset(input int n);
        @(negedge mclk);
        #1;
        rst = 1'b1;
        pair_valid = 1'b0;
        last_acc = 0;
        q_data.delete();
        q_edge.delete();
        repeat (n) @(negedge mclk);
        #1;
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(4);

        // directed corner values: extremes and alternating bits
        send(16'h8000, 16'h7FFF);
        send(16'hFFFF, 16'h0001);
        send(16'h0000, 16'hFFFF);
        send(16'hAAAA, 16'h5555);
        send(16'h1234, 16'hABCD);

        // random pairs with random gaps landing at every frame phase
        for (int k = 0; k < 40; k++) begin
            if ($urandom % 4 == 0)
                idle(int'($urandom % 300));
            send(W'($urandom), W'($urandom));
        end

        // long idle: silent frames, ready stays high (R7)
        idle(300);
        for (int k = 0; k < 12; k++) begin
            idle(64);
            check(pair_ready == 1'b1, "R7", "ready while idle", pair_ready, 1);
        end

        // reset in the middle of a frame with a pair held
        send(16'h0F0F, 16'hF0F0);
        idle(100);
        do_reset(3);
        send(16'h4321, 16'h8765);
        send(16'h0001, 16'h8000);
        send(16'h7FFF, 16'hFFFE);

        idle(3 * SLOTS * DIV);
        check(q_data.size() == 0, "R6", "pairs left unsent", q_data.size(), 0);
        check(frames_done > 50, "R6", "frames observed", frames_done, 51);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge mclk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R1: actual cycles %0d expected below %0d", cyc, 200000);
        finish_run();
    end

endmodule